// File: doc/BRIEF.md
# External Memory Bus Decoder and Arbiter

This block owns the external memory bus of a small system. Three masters (a sound engine, a picture processor and the CPU) each present a request and a word address. The block picks one of them using a fixed priority order chosen in a configuration register. It holds that grant for the whole access and decodes the granted address into a ROM chip select or an external RAM chip select. It also stretches each external access by a programmable number of wait states.

The 12-bit configuration register is written in one cycle. Its fields are: bit 0, the clock-output enable; bits 2..1, the wait-state count; bits 5..3, the arbitration order; bits 7..6, the ROM map; bits 11..8, the RAM window. Accesses below the start of external space take no chip select and no wait state. When a RAM window and the ROM map both cover an address, the RAM window takes precedence.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset no requester is granted, both chip selects and `ack` are low, `bus_addr` is zero and `clk_oe` is low; the configuration resets to all zeros.
- R2: Requester indices are 0 sound, 1 picture, 2 CPU. With arbitration field (bits 5..3) equal to 101, or any code other than 111, the order is sound, then picture, then CPU.
- R3: With arbitration field 111 the order is picture, then sound, then CPU.
- R4: An access starts on the clock edge after arbitration with a one-hot `gnt`. The grant stays unchanged for wait+1 cycles, and `ack` is high only in the last of them. A new arbitration happens at that last edge, so back-to-back grants are possible.
- R5: For addresses at or above 0x4000 the wait count is config bits 2..1 (0 to 3) as it stood at grant time.
- R6: Addresses below 0x4000 assert neither chip select and complete with `ack` in their first granted cycle.
- R7: ROM field (bits 7..6): 00 selects ROM for all external addresses, 01 only where the address MSB is 0, and 1x only where the two top bits are 00.
- R8: RAM field (bits 11..8): 0xxx maps no RAM. 1nnn selects RAM where the top nnn+1 address bits are all ones.
- R9: Where RAM is selected, `rom_sel` is low.
- R10: `clk_oe` equals config bit 0 from the cycle after the write.
- R11: `bus_addr` carries the granted requester's address throughout the access and is zero when idle.
- R12: A configuration write during an access changes neither its chip selects nor its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 12 | Configuration value |
| req | input | 3 | Requests: 0 sound, 1 picture, 2 CPU |
| req_addr | input | 3 x ADDR_W | Word address per requester |
| gnt | output | 3 | One-hot grant of the running access |
| bus_addr | output | ADDR_W | Address of the running access |
| rom_sel | output | 1 | ROM chip select |
| ram_sel | output | 1 | External RAM chip select |
| ack | output | 1 | Last cycle of the running access |
| clk_oe | output | 1 | External clock output enable |

## Verification
Two events collide often in this block. The first is a configuration write in the same cycle as a new grant or in the middle of an access. The second is a completing access (`ack`) in the same cycle as fresh or held requests. Random traffic keeps requests pending from several masters and writes the register at random moments, so both collisions happen many times. A reference model applies the old configuration at the grant edge and holds decode and length fixed until `ack`. It is compared with grant, selects, address and `ack` in every cycle.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    localparam int NREQ    = 3;
    localparam int REQ_SND = 0;
    localparam int REQ_PIC = 1;
    localparam int REQ_CPU = 2;
    localparam int CFG_W   = 12;

    typedef struct packed {
        logic [3:0] ram_win;
        logic [1:0] rom_map;
        logic [2:0] arb_ord;
        logic [1:0] wait_n;
        logic       clk_en;
    } xbus_cfg_t;
endpackage

// File: rtl/xbus_decode.sv
module xbus_decode
    import xbus_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int EXT_BASE = 'h4000
) (
    input  logic [ADDR_W-1:0] addr,
    input  xbus_cfg_t         cfg,
    output logic              is_ext,
    output logic              rom_hit,
    output logic              ram_hit
);
    localparam int MSB = ADDR_W - 1;
    logic ram_win_hit;
    logic rom_raw;

    always_comb begin
        is_ext = (addr >= ADDR_W'(EXT_BASE));
        ram_win_hit = cfg.ram_win[3];
        for (int i = 0; i < 8; i++) begin
            if (i <= int'(cfg.ram_win[2:0])) begin
                ram_win_hit = ram_win_hit & addr[MSB-i];
            end
        end
        ram_hit = is_ext & ram_win_hit;
        unique case (cfg.rom_map)
            2'b00:   rom_raw = 1'b1;
            2'b01:   rom_raw = ~addr[MSB];
            default: rom_raw = (addr[MSB -: 2] == 2'b00);
        endcase
        rom_hit = is_ext & rom_raw & ~ram_hit;
    end
endmodule

// File: rtl/xbus_arbiter.sv
module xbus_arbiter
    import xbus_pkg::*;
(
    input  logic [NREQ-1:0] req,
    input  logic [2:0]      arb_ord,
    output logic [NREQ-1:0] win
);
    logic [NREQ-1:0][1:0] order;

    always_comb begin
        if (arb_ord == 3'b111) begin
            order[0] = 2'(REQ_PIC);
            order[1] = 2'(REQ_SND);
        end else begin
            order[0] = 2'(REQ_SND);
            order[1] = 2'(REQ_PIC);
        end
        order[2] = 2'(REQ_CPU);
        win = '0;
        for (int k = NREQ - 1; k >= 0; k--) begin
            if (req[order[k]]) begin
                win = '0;
                win[order[k]] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int EXT_BASE = 'h4000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [CFG_W-1:0]             cfg_wdata,
    input  logic [NREQ-1:0]              req,
    input  logic [NREQ-1:0][ADDR_W-1:0]  req_addr,
    output logic [NREQ-1:0]              gnt,
    output logic [ADDR_W-1:0]            bus_addr,
    output logic                         rom_sel,
    output logic                         ram_sel,
    output logic                         ack,
    output logic                         clk_oe
);
    typedef struct packed {
        logic              busy;
        logic [NREQ-1:0]   gnt;
        logic [ADDR_W-1:0] addr;
        logic              rom;
        logic              ram;
        logic [1:0]        cnt;
        xbus_cfg_t         cfg;
    } state_t;

    state_t st_q, st_d;

    logic [NREQ-1:0]   win;
    logic [ADDR_W-1:0] win_addr;
    logic              w_ext, w_rom, w_ram;

    xbus_arbiter u_arb (
        .req     (req),
        .arb_ord (st_q.cfg.arb_ord),
        .win     (win)
    );

    always_comb begin
        win_addr = '0;
        for (int r = 0; r < NREQ; r++) begin
            if (win[r]) win_addr = req_addr[r];
        end
    end

    xbus_decode #(.ADDR_W(ADDR_W), .EXT_BASE(EXT_BASE)) u_dec (
        .addr    (win_addr),
        .cfg     (st_q.cfg),
        .is_ext  (w_ext),
        .rom_hit (w_rom),
        .ram_hit (w_ram)
    );

    logic done;
    assign done = st_q.busy && (st_q.cnt == 2'd0);

    always_comb begin
        st_d = st_q;
        if (cfg_we) st_d.cfg = xbus_cfg_t'(cfg_wdata);
        if (st_q.busy && !done) begin
            st_d.cnt = st_q.cnt - 2'd1;
        end else if (|req) begin
            st_d.busy = 1'b1;
            st_d.gnt  = win;
            st_d.addr = win_addr;
            st_d.rom  = w_rom;
            st_d.ram  = w_ram;
            st_d.cnt  = w_ext ? st_q.cfg.wait_n : 2'd0;
        end else begin
            st_d.busy = 1'b0;
            st_d.gnt  = '0;
            st_d.addr = '0;
            st_d.rom  = 1'b0;
            st_d.ram  = 1'b0;
            st_d.cnt  = 2'd0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gnt      = st_q.gnt;
    assign bus_addr = st_q.addr;
    assign rom_sel  = st_q.rom;
    assign ram_sel  = st_q.ram;
    assign ack      = done;
    assign clk_oe   = st_q.cfg.clk_en;
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk
    import xbus_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int EXT_BASE = 'h4000
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cfg_we,
    input logic [CFG_W-1:0]            cfg_wdata,
    input logic [NREQ-1:0]             req,
    input logic [NREQ-1:0][ADDR_W-1:0] req_addr,
    input logic [NREQ-1:0]             gnt,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic                        rom_sel,
    input logic                        ram_sel,
    input logic                        ack,
    input logic                        clk_oe
);
    // R4
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    // R4
    ack_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (gnt != '0));
    // R4
    gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt != '0) && !ack) |=> ($stable(gnt) && $stable(bus_addr)));
    // R9
    sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_sel && ram_sel));
    // R8
    ram_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_sel |-> bus_addr[ADDR_W-1]);
    // R6
    sel_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sel || ram_sel) |-> (bus_addr >= ADDR_W'(EXT_BASE)));
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == '0) |-> (!rom_sel && !ram_sel && !ack));
    // R10
    clk_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (clk_oe == $past(cfg_wdata[0])));
endmodule

bind xbus_ctrl xbus_ctrl_chk #(.ADDR_W(ADDR_W), .EXT_BASE(EXT_BASE)) u_chk (.*);

// File: tb/xbus_ctrl_bench.sv
module xbus_ctrl_bench;
    localparam int AW   = 22;
    localparam int BASE = 'h4000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [11:0] cfg_wdata = '0;
    logic [2:0] req = '0;
    logic [2:0][AW-1:0] req_addr = '0;
    logic [2:0] gnt;
    logic [AW-1:0] bus_addr;
    logic rom_sel, ram_sel, ack, clk_oe;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    xbus_ctrl #(.ADDR_W(AW), .EXT_BASE(BASE)) u_xbus_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req(req), .req_addr(req_addr), .gnt(gnt), .bus_addr(bus_addr),
        .rom_sel(rom_sel), .ram_sel(ram_sel), .ack(ack), .clk_oe(clk_oe)
    );

    // reference model state
    logic [11:0]   m_cfg;
    logic          m_busy;
    logic [2:0]    m_gnt;
    logic [AW-1:0] m_addr;
    logic          m_rom, m_ram;
    logic [1:0]    m_cnt;
    logic          m_ack;
    assign m_ack = m_busy && (m_cnt == 2'd0);

    function automatic logic f_ram(input logic [11:0] c, input logic [AW-1:0] a);
        int n;
        if (a < AW'(BASE) || !c[11]) return 1'b0;
        n = int'(c[10:8]);
        for (int i = 0; i <= n; i++) if (!a[AW-1-i]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic f_rom(input logic [11:0] c, input logic [AW-1:0] a);
        if (a < AW'(BASE) || f_ram(c, a)) return 1'b0;
        if (c[7:6] == 2'b00) return 1'b1;
        if (c[7:6] == 2'b01) return !a[AW-1];
        return a[AW-1:AW-2] == 2'b00;
    endfunction

    function automatic int f_pick(input logic [11:0] c, input logic [2:0] r);
        if (c[5:3] == 3'b111) begin
            if (r[1]) return 1;
            if (r[0]) return 0;
        end else begin
            if (r[0]) return 0;
            if (r[1]) return 1;
        end
        return 2;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cfg <= '0; m_busy <= 0; m_gnt <= '0; m_addr <= '0;
            m_rom <= 0; m_ram <= 0; m_cnt <= '0;
        end else begin
            if (cfg_we) m_cfg <= cfg_wdata;
            if (m_busy && !m_ack) begin
                m_cnt <= m_cnt - 2'd1;
            end else if (req != 3'b000) begin
                int w;
                w = f_pick(m_cfg, req);
                m_busy <= 1;
                m_gnt  <= 3'b001 << w;
                m_addr <= req_addr[w];
                m_rom  <= f_rom(m_cfg, req_addr[w]);
                m_ram  <= f_ram(m_cfg, req_addr[w]);
                m_cnt  <= (req_addr[w] >= AW'(BASE)) ? m_cfg[2:1] : 2'd0;
            end else begin
                m_busy <= 0; m_gnt <= '0; m_addr <= '0;
                m_rom <= 0; m_ram <= 0; m_cnt <= '0;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        check("R2/R3/R4 gnt", 32'(gnt), 32'(m_gnt));
        check("R4/R5/R6 ack", 32'(ack), 32'(m_ack));
        check("R7/R9/R12 rom_sel", 32'(rom_sel), 32'(m_rom));
        check("R8/R12 ram_sel", 32'(ram_sel), 32'(m_ram));
        check("R11 bus_addr", 32'(bus_addr), 32'(m_addr));
        check("R10 clk_oe", 32'(clk_oe), 32'(m_cfg[0]));
    endtask

    function automatic logic [AW-1:0] rnd_addr();
        int k;
        logic [AW-1:0] a;
        a = AW'($urandom);
        case ($urandom_range(0, 3))
            0: a = AW'($urandom_range(0, BASE - 1));
            1: begin
                k = $urandom_range(1, 8);
                for (int i = 0; i < k; i++) a[AW-1-i] = 1'b1;
            end
            2: a[AW-1 -: 2] = 2'($urandom_range(0, 1));
            default: ;
        endcase
        return a;
    endfunction

    function automatic logic [11:0] rnd_cfg();
        logic [11:0] c;
        c = 12'($urandom);
        case ($urandom_range(0, 2))
            0: c[5:3] = 3'b101;
            1: c[5:3] = 3'b111;
            default: ;
        endcase
        return c;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 gnt", 32'(gnt), 0);
        check("R1 sel", 32'({rom_sel, ram_sel, ack}), 0);
        check("R1 bus_addr/clk_oe", 32'({bus_addr, clk_oe}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 clock enable follows bit 0; R3 picture wins with code 111
        cfg_we = 1; cfg_wdata = 12'b0000_00_111_11_1;
        @(negedge clk);
        cfg_we = 0;
        check("R10 clk_oe set", 32'(clk_oe), 1);
        req = 3'b111;
        req_addr[0] = AW'('h4100); req_addr[1] = AW'('h100); req_addr[2] = AW'('h5000);
        @(negedge clk);
        check("R3 picture first", 32'(gnt), 32'(3'b010));
        check("R6 low address no wait", 32'({ack, rom_sel, ram_sel}), 32'(3'b100));
        check_all();
        req[1] = 0;
        @(negedge clk);
        check("R3 sound second", 32'(gnt), 32'(3'b001));
        check("R5 three waits pending", 32'(ack), 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_all();
        end
        req = 3'b000;
        // random phase
        for (int cyc = 0; cyc < 6000; cyc++) begin
            @(negedge clk);
            check_all();
            for (int r = 0; r < 3; r++) begin
                if (gnt[r] && ack) begin
                    req[r] = ($urandom_range(0, 1) == 1);
                    req_addr[r] = rnd_addr();
                end else if (!req[r] && $urandom_range(0, 9) < 3) begin
                    req[r] = 1;
                    req_addr[r] = rnd_addr();
                end
            end
            cfg_we = ($urandom_range(0, 19) == 0);
            cfg_wdata = rnd_cfg();
        end
        cfg_we = 0;
        req = 0;
        repeat (6) @(negedge clk);
        check_all();
        check("R1 idle after drain", 32'(gnt), 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule